// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block raises the input-change interrupt for a 16-bit general-purpose input expander built from two 8-bit ports. For each port it keeps a snapshot of the value last handed to the host. Every live input bit, after synchronization, is compared with its snapshot bit. Any difference on either port drives a shared active-low interrupt request. The request is presented as an output enable for an open-drain pad, so the pad either sinks the line or releases it.

The host clears a change by reading the port that holds it. A read strobe with a port-select bit returns the synchronized value of that port in the same cycle. On the same clock edge the snapshot of that port, and only that port, loads the returned value. Each port therefore clears independently. The shared request stays asserted without a break for as long as either port still differs from its snapshot. There is no timeout.

Top module: `port_change_irq`

## Requirements
- R1: While `rst_n` is low, `int_oe` is 0. Each snapshot loads its port's synchronized input on every reset cycle, so after a reset held for at least three cycles with steady inputs, `int_oe` stays 0.
- R2: A port's snapshot changes only on a clock edge where `rd_stb` is 1 and `rd_sel` selects that port. On that edge it captures the value returned on `rd_data`. An unstrobed `rd_sel` has no effect.
- R3: A read of port A (`rd_sel`=0) leaves the port B snapshot unchanged, and a read of port B (`rd_sel`=1) leaves the port A snapshot unchanged.
- R4: A mismatch between any live bit and its snapshot bit, on either port, asserts `int_oe`. A single bit is enough.
- R5: An input change passes two synchronizer flops and one output flop. `int_oe` rises at the third rising clock edge after the change, and not before.
- R6: When a read clears one port while the other port has a pending mismatch, `int_oe` stays 1 in every cycle, with no release in between.
- R7: A pending mismatch keeps `int_oe` at 1 for as long as the port is left unread.
- R8: If an input returns to its snapshot value before any read, its condition clears by itself, and `int_oe` falls when no other bit differs.
- R9: While `rd_stb` is 1, `rd_data` shows in the same cycle the synchronized value of the selected port (0 = port A, 1 = port B). While `rd_stb` is 0, `rd_data` is 0.
- R10: After a read clears the only pending port, `int_oe` falls at the second rising edge counted from the start of the strobe cycle.
- R11: `int_lvl`, the value given to the open-drain pad, is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the snapshots |
| port_a_in | input | 8 | Asynchronous inputs of port A |
| port_b_in | input | 8 | Asynchronous inputs of port B |
| rd_stb | input | 1 | One-cycle read of an input port |
| rd_sel | input | 1 | Port select for the read: 0 = A, 1 = B |
| rd_data | output | 8 | Synchronized value of the selected port |
| int_oe | output | 1 | Open-drain enable: 1 sinks the interrupt line |
| int_lvl | output | 1 | Pad data value, held at 0 |

## Verification
Every bit of both ports is toggled one at a time. Each toggle confirms that a single-bit difference raises the request at exactly the third edge. It also confirms that reading the other port leaves the request in place, and that reading the owning port releases it. A set of computed multi-bit patterns changes both ports together, or only one of them. These patterns separate the port-local clear from a shared clear. The overlap sequence and the long unread wait sample the request every cycle to catch a single-cycle release. The return-to-snapshot case, the unstrobed select and a fresh reset with new input values show that the snapshot follows only a read or a reset, and never the live inputs.

// File: rtl/pcig_pkg.sv
package pcig_pkg;

   localparam int unsigned PCIG_NUM_PORTS = 2;
   localparam int unsigned PCIG_SEL_W     = 1;

   typedef enum logic [PCIG_SEL_W-1:0] {
      PCIG_SEL_A = 1'b0,
      PCIG_SEL_B = 1'b1
   } pcig_sel_e;

   function automatic logic pcig_any(input logic [PCIG_NUM_PORTS-1:0] v);
      return |v;
   endfunction

endpackage

// File: rtl/pcig_sync.sv
module pcig_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int unsigned LAST = STAGES - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("pcig_sync: WIDTH must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("pcig_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      stage_q[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[LAST];

endmodule

// File: rtl/pcig_port_track.sv
module pcig_port_track #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] live,
   input  logic             rd_hit,
   output logic [WIDTH-1:0] snap,
   output logic [WIDTH-1:0] diff_bits,
   output logic             pend
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pcig_port_track: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] snap_q;
   logic             load;

   // Reset reloads from the live value every cycle; afterwards only a read does.
   assign load = !rst_n || rd_hit;

   always_ff @(posedge clk) begin
      if (load) begin
         snap_q <= live;
      end
   end

   assign snap      = snap_q;
   assign diff_bits = live ^ snap_q;
   assign pend      = |diff_bits;

   // R2: a read captures exactly the value present in the read cycle
   p_snap_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> snap_q == $past(live));

   // R3: without a read of this port the snapshot holds
   p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> $stable(snap_q));

   // R2: right after a read this port is clear unless the input moved since
   p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (pend == (live != $past(live))));

endmodule

// File: rtl/pcig_irq_out.sv
module pcig_irq_out
   import pcig_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [PCIG_NUM_PORTS-1:0] port_pend,
   output logic                      int_oe
);

   logic any_pend;

   assign any_pend = pcig_any(port_pend);

   if (REGISTERED) begin : g_reg
      logic oe_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            oe_q <= 1'b0;
         end else begin
            oe_q <= any_pend;
         end
      end

      assign int_oe = oe_q;

      // R4: any pending port drives the line at the following edge
      p_pend_pulls_r4: assert property (@(posedge clk) disable iff (!rst_n)
         any_pend |=> int_oe);

      // R8: with nothing pending the line is released at the following edge
      p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !any_pend |=> !int_oe);

      // R6: pending on consecutive cycles never yields a released cycle
      p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (any_pend && $past(any_pend)) |=> (int_oe && $past(int_oe)));

      // R1: first cycle after reset the line is released
      p_reset_idle_r1: assert property (@(posedge clk)
         $rose(rst_n) |-> !int_oe);
   end else begin : g_comb
      assign int_oe = rst_n && any_pend;
   end

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
   import pcig_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_FLOP    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_a_in,
   input  logic [PORT_W-1:0] port_b_in,
   input  logic              rd_stb,
   input  logic              rd_sel,
   output logic [PORT_W-1:0] rd_data,
   output logic              int_oe,
   output logic              int_lvl
);

   localparam int unsigned NPORT = PCIG_NUM_PORTS;

   if (PORT_W < 1 || PORT_W > 32) begin : g_bad_port_w
      $error("port_change_irq: PORT_W out of range 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("port_change_irq: SYNC_STAGES must be at least 2");
   end

   logic [PORT_W-1:0] raw_in    [NPORT];
   logic [PORT_W-1:0] live      [NPORT];
   logic [PORT_W-1:0] snap      [NPORT];
   logic [PORT_W-1:0] diff_bits [NPORT];
   logic [NPORT-1:0]  rd_hit;
   logic [NPORT-1:0]  port_pend;
   pcig_sel_e         sel;

   assign raw_in[0] = port_a_in;
   assign raw_in[1] = port_b_in;
   assign sel       = pcig_sel_e'(rd_sel);

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      pcig_sync #(
         .WIDTH  (PORT_W),
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk      (clk),
         .async_in (raw_in[p]),
         .sync_out (live[p])
      );

      assign rd_hit[p] = rd_stb && (sel == pcig_sel_e'(p));

      pcig_port_track #(
         .WIDTH (PORT_W)
      ) u_track (
         .clk       (clk),
         .rst_n     (rst_n),
         .live      (live[p]),
         .rd_hit    (rd_hit[p]),
         .snap      (snap[p]),
         .diff_bits (diff_bits[p]),
         .pend      (port_pend[p])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NPORT; p++) begin
         if (rd_hit[p]) begin
            rd_data = live[p];
         end
      end
   end

   pcig_irq_out #(
      .REGISTERED (IRQ_FLOP)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_pend (port_pend),
      .int_oe    (int_oe)
   );

   assign int_lvl = 1'b0;

   // R3: at most one port is read per cycle
   p_one_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_hit));

   // R9: the value returned equals the snapshot it leaves behind
   p_data_matches_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> snap[$past(rd_sel)] == $past(rd_data));

   // R1: reset forces the line released
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> !int_oe || $past(rst_n));

endmodule

// File: tb/port_change_irq_bench.sv
module port_change_irq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pa = 8'h00;
   logic [7:0] pb = 8'h00;
   logic       rd_stb = 1'b0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic       int_oe;
   logic       int_lvl;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   port_change_irq u_port_change_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_a_in (pa),
      .port_b_in (pb),
      .rd_stb    (rd_stb),
      .rd_sel    (rd_sel),
      .rd_data   (rd_data),
      .int_oe    (int_oe),
      .int_lvl   (int_lvl)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic wait3();
      tick(); tick(); tick();
   endtask

   task automatic do_read(input logic sel, input logic [7:0] exp);
      rd_sel = sel;
      rd_stb = 1'b1;
      #1;
      chk("R9 read data", int'(rd_data), int'(exp));
      tick();
      rd_stb = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int drops;
      logic [7:0] old;
      // R1: reset
      pa = 8'h5A; pb = 8'hC3;
      repeat (5) tick();
      chk("R1 oe in reset", int'(int_oe), 0);
      chk("R11 pad value", int'(int_lvl), 0);
      rst_n = 1'b1;
      drops = 0;
      repeat (6) begin tick(); if (int_oe) drops++; end
      chk("R1 idle after reset", drops, 0);
      chk("R9 idle rd_data", int'(rd_data), 0);

      // R4/R5/R3/R10: every bit of both ports
      for (int p = 0; p < 2; p++) begin
         for (int b = 0; b < 8; b++) begin
            if (p == 0) pa = pa ^ (8'h01 << b);
            else        pb = pb ^ (8'h01 << b);
            tick(); tick();
            chk("R5 not before third edge", int'(int_oe), 0);
            tick();
            chk("R4 single bit asserts", int'(int_oe), 1);
            do_read(p == 0, (p == 0) ? pb : pa);
            tick();
            chk("R3 other read keeps pending", int'(int_oe), 1);
            do_read(p == 1, (p == 0) ? pa : pb);
            chk("R10 edge after read still on", int'(int_oe), 1);
            tick();
            chk("R10 release after read", int'(int_oe), 0);
            chk("R11 pad value", int'(int_lvl), 0);
         end
      end

      // R4/R3: multi-bit patterns on both ports
      for (int i = 0; i < 16; i++) begin
         logic [7:0] na, nb;
         logic b_chg;
         na = 8'(i * 37 + 11);
         if (na == pa) na = na ^ 8'h01;
         nb = (i % 4 == 0) ? pb : 8'(i * 91 + 5);
         b_chg = (nb != pb);
         pa = na; pb = nb;
         wait3();
         chk("R4 pattern asserts", int'(int_oe), 1);
         do_read(1'b0, pa);
         tick();
         chk("R3 port-local clear", int'(int_oe), int'(b_chg));
         do_read(1'b1, pb);
         tick();
         chk("R10 pattern release", int'(int_oe), 0);
      end

      // R6: overlapping clear on one port and new change on the other
      pb = pb ^ 8'h01;
      wait3();
      chk("R6 port B pending", int'(int_oe), 1);
      drops = 0;
      do_read(1'b0, pa);
      if (!int_oe) drops++;
      pa = pa ^ 8'h01;
      repeat (4) begin tick(); if (!int_oe) drops++; end
      do_read(1'b1, pb);
      if (!int_oe) drops++;
      repeat (6) begin tick(); if (!int_oe) drops++; end
      chk("R6 no release cycles", drops, 0);
      do_read(1'b0, pa);
      tick();
      chk("R10 release after overlap", int'(int_oe), 0);

      // R7: unread port holds the request
      pa = pa ^ 8'h80;
      wait3();
      drops = 0;
      repeat (3000) begin tick(); if (!int_oe) drops++; end
      chk("R7 held while unread", drops, 0);
      do_read(1'b0, pa);
      tick();
      chk("R10 release after long wait", int'(int_oe), 0);

      // R8: input returns on its own
      pb = pb ^ 8'h10;
      wait3();
      chk("R8 asserted", int'(int_oe), 1);
      pb = pb ^ 8'h10;
      wait3();
      chk("R8 self clear", int'(int_oe), 0);

      // R2: snapshot follows the read, not the input history
      old = pa;
      pa = 8'h3C ^ old ^ 8'hFF;
      wait3();
      do_read(1'b0, pa);
      tick();
      chk("R2 read clears", int'(int_oe), 0);
      pa = old;
      wait3();
      chk("R2 snapshot holds read value", int'(int_oe), 1);
      rd_stb = 1'b0;
      rd_sel = 1'b0;
      repeat (3) tick();
      rd_sel = 1'b1;
      repeat (2) tick();
      chk("R2 unstrobed select ignored", int'(int_oe), 1);
      chk("R9 no strobe zero data", int'(rd_data), 0);
      do_read(1'b0, pa);
      tick();
      chk("R2 cleared", int'(int_oe), 0);

      // R1: reset reloads snapshots with new input values
      pa = 8'hA5; pb = 8'h69;
      rst_n = 1'b0;
      tick();
      chk("R1 oe in reset", int'(int_oe), 0);
      repeat (4) tick();
      rst_n = 1'b1;
      drops = 0;
      repeat (6) begin tick(); if (int_oe) drops++; end
      chk("R1 no pending after reset", drops, 0);
      do_read(1'b1, 8'h69);
      tick();
      chk("R1 still idle", int'(int_oe), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule